// File: doc/BRIEF.md
# Hysteresis Level Trigger Detector

This block watches either a stream of signed digitized samples or a single asynchronous digital trigger pin, and raises a trigger output when a programmed condition is met. In analog mode each valid sample is compared with a programmed threshold. The trigger fires when the signal reaches the threshold in the selected direction. Another trigger is allowed only after the signal has moved back past a hysteresis band on the far side of the threshold. This keeps noise around the threshold from producing bursts of triggers.

In digital mode the pin is synchronized and qualified by a run-length counter. A high pulse shorter than the programmed minimum width is discarded. A qualified pulse produces either a single-cycle trigger when it starts (edge response) or an output that stays high for as long as the pin stays qualified (level response). A global arm input enables the detector. While arm is low nothing fires. Re-arming always starts from a state that must first see the re-arm condition.

Top module: `hyst_trigger`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with `armEn` low, `trigOut` is low, whatever the samples or the pin do.
- R2: Analog rising slope (`modeDigital`=0, `slopeFall`=0): a valid sample with value >= `trigLevel`, taken while the detector is ready, makes `trigOut` high for exactly the cycle after that sample's clock edge.
- R3: Analog falling slope (`slopeFall`=1): a valid sample with value <= `trigLevel`, taken while ready, makes `trigOut` high for exactly the cycle after that sample's clock edge.
- R4: With the rising slope, after arming and after each trigger, the detector becomes ready only on a valid sample strictly below `trigLevel - hystWidth`. Samples between that bound and the level neither trigger nor re-arm.
- R5: With the falling slope, the detector becomes ready only on a valid sample strictly above `trigLevel + hystWidth`.
- R6: Samples, `trigLevel` and the band limits are signed two's complement. `hystWidth` is unsigned. Each band limit is clamped to the most negative or most positive sample value and never wraps. A band clamped to the end of the range therefore never re-arms.
- R7: A sample presented with `sampleValid` low is ignored: it neither triggers nor re-arms.
- R8: Digital edge response (`modeDigital`=1, `digLevel`=0): a qualified high pulse on `digIn` gives one single-cycle trigger. If the pin is high from clock edge P+1 to edge P+N with N >= max(`minWidth`,1), `trigOut` is high only in the cycle after edge P+2+max(`minWidth`,1), after a two-stage synchronizer.
- R9: Digital level response (`digLevel`=1): for the same pulse, `trigOut` is high in every cycle after edges P+2+max(`minWidth`,1) through P+N+2.
- R10: A digital pulse seen high at fewer than max(`minWidth`,1) consecutive clock edges produces no trigger in either response. The run counter saturates, so pulses longer than its range stay qualified.
- R11: Lowering `armEn` returns the detector to the disarmed state. After `armEn` rises again, an analog trigger first needs a new re-arm sample, even if the detector was ready before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| armEn | input | 1 | Global arm; low keeps the detector disarmed |
| modeDigital | input | 1 | 0 selects sample comparison, 1 selects the digital pin |
| slopeFall | input | 1 | 0 fires on rising crossings, 1 on falling crossings |
| digLevel | input | 1 | Digital mode only: 0 edge response, 1 level response |
| sampleIn | input | SAMPLE_W | Signed sample value |
| sampleValid | input | 1 | Qualifies `sampleIn` in the current cycle |
| trigLevel | input | SAMPLE_W | Signed threshold |
| hystWidth | input | SAMPLE_W | Unsigned hysteresis band width |
| minWidth | input | CNT_W | Minimum digital pulse width in clock cycles |
| digIn | input | 1 | Asynchronous digital trigger pin |
| trigOut | output | 1 | Trigger output |

## Verification
The bench builds the detector with 8-bit samples and a 4-bit run counter. With 8-bit samples, a threshold near either end of the range and a band of 50 codes pushes the band limit past the end of the range, so the clamp is exercised where a wrapped limit would visibly re-arm. The 4-bit counter lets a minimum width of 15 and a 20-cycle pulse drive the counter into saturation in a short run, and pulses one cycle short of the minimum show the rejection boundary.

// File: rtl/hyst_trigger_pkg.sv
package hyst_trigger_pkg;

  // Detector state: off (disarmed), hunting for the re-arm condition, ready to fire.
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_HUNT  = 2'd1,
    ST_READY = 2'd2
  } trigState_e;

  // Condition flags produced by the datapath each cycle.
  typedef struct packed {
    logic fireHit;    // valid sample on the firing side of the level
    logic rearmHit;   // valid sample beyond the hysteresis band
    logic qualLevel;  // synchronized pin high for at least the minimum width
    logic qualEdge;   // first cycle of qualLevel
  } dpFlags_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic runClear;   // hold the run counter at zero while disarmed
  } ctrlStrb_t;

endpackage

// File: rtl/hyst_trigger_dp.sv
module hyst_trigger_dp
  import hyst_trigger_pkg::*;
#(
  parameter int SAMPLE_W    = 14,
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                slopeFall,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] trigLevel,
  input  logic [SAMPLE_W-1:0] hystWidth,
  input  logic [CNT_W-1:0]    minWidth,
  input  logic                digIn,
  input  ctrlStrb_t           strb,
  output dpFlags_t            flags
);

  localparam int EXT_W = SAMPLE_W + 2;
  localparam logic signed [EXT_W-1:0] MAX_EXT = EXT_W'((64'sd1 <<< (SAMPLE_W - 1)) - 64'sd1);
  localparam logic signed [EXT_W-1:0] MIN_EXT = -MAX_EXT - EXT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // ---------------- analog comparison path ----------------
  logic signed [EXT_W-1:0] sampleExt, levelExt, hystExt;
  logic signed [EXT_W-1:0] lowRaw, highRaw, lowSat, highSat;

  assign sampleExt = {{2{sampleIn[SAMPLE_W-1]}}, sampleIn};
  assign levelExt  = {{2{trigLevel[SAMPLE_W-1]}}, trigLevel};
  assign hystExt   = {2'b00, hystWidth};
  assign lowRaw    = levelExt - hystExt;
  assign highRaw   = levelExt + hystExt;

  // Clamp the band limits to the representable sample range.
  always_comb begin
    lowSat  = (lowRaw  < MIN_EXT) ? MIN_EXT : lowRaw;
    highSat = (highRaw > MAX_EXT) ? MAX_EXT : highRaw;
  end

  logic atOrPast, beyondBand;
  always_comb begin
    if (slopeFall) begin
      atOrPast   = (sampleExt <= levelExt);
      beyondBand = (sampleExt >  highSat);
    end else begin
      atOrPast   = (sampleExt >= levelExt);
      beyondBand = (sampleExt <  lowSat);
    end
  end

  assign flags.fireHit  = sampleValid && atOrPast;
  assign flags.rearmHit = sampleValid && beyondBand;

  // R6: the band limits bracket the level and never wrap past it.
  a_r6_band_ordered: assert property (@(posedge clk) disable iff (!rstN)
    (lowSat <= levelExt) && (levelExt <= highSat));

  // ---------------- digital pin path ----------------
  logic [SYNC_STAGES-1:0] syncChain;
  generate
    for (genvar gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[gi] <= 1'b0;
          else       syncChain[gi] <= digIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[gi] <= 1'b0;
          else       syncChain[gi] <= syncChain[gi-1];
        end
      end
    end
  endgenerate

  logic syncHi;
  assign syncHi = syncChain[SYNC_STAGES-1];

  // Run counter: number of earlier consecutive high cycles, saturating.
  logic [CNT_W-1:0] runCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        runCnt <= '0;
    else if (strb.runClear || !syncHi) runCnt <= '0;
    else if (runCnt != CNT_MAX)       runCnt <= runCnt + CNT_ONE;
  end

  logic [CNT_W:0] runThis;
  logic           qualNow, qualPrev;
  assign runThis = {1'b0, runCnt} + {{CNT_W{1'b0}}, 1'b1};
  assign qualNow = syncHi && !strb.runClear && (runThis >= {1'b0, minWidth});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) qualPrev <= 1'b0;
    else       qualPrev <= qualNow;
  end

  assign flags.qualLevel = qualNow;
  assign flags.qualEdge  = qualNow && !qualPrev;

  // R10: with a minimum above one, qualification can only begin after a high cycle.
  a_r10_qual_after_high: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(qualNow) && $stable(minWidth) && (minWidth > CNT_ONE)) |-> $past(syncHi));

endmodule

// File: rtl/hyst_trigger_ctrl.sv
module hyst_trigger_ctrl
  import hyst_trigger_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      armEn,
  input  logic      modeDigital,
  input  logic      digLevel,
  input  dpFlags_t  flags,
  output ctrlStrb_t strb,
  output logic      trigOut
);

  trigState_e state, stateNext;
  logic       armed, trigNext, holdKind;

  assign armed = (state != ST_OFF);

  always_comb begin
    stateNext = state;
    if (!armEn) begin
      stateNext = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:   stateNext = ST_HUNT;
        ST_HUNT:  if (!modeDigital && flags.rearmHit) stateNext = ST_READY;
        ST_READY: if (!modeDigital && flags.fireHit)  stateNext = ST_HUNT;
        default:  stateNext = ST_OFF;
      endcase
    end
  end

  always_comb begin
    trigNext = 1'b0;
    if (armEn && armed) begin
      if (modeDigital) trigNext = digLevel ? flags.qualLevel : flags.qualEdge;
      else             trigNext = (state == ST_READY) && flags.fireHit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_OFF;
      trigOut  <= 1'b0;
      holdKind <= 1'b0;
    end else begin
      state    <= stateNext;
      trigOut  <= trigNext;
      holdKind <= armEn && armed && modeDigital && digLevel;
    end
  end

  assign strb.runClear = !armed;

  // R1: a low arm input silences the output in the following cycle.
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !armEn |=> !trigOut);

  // R4: in analog mode nothing fires unless the detector was ready.
  a_r4_hunt_blocks_fire: assert property (@(posedge clk) disable iff (!rstN)
    (armEn && !modeDigital && state != ST_READY) |=> !trigOut);

  // R8: pulse-type triggers last one cycle.
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (trigOut && !holdKind) |=> !trigOut);

  // R11: leaving the disarmed state always goes through hunting.
  a_r11_rearm_via_hunt: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF) |=> (state != ST_READY));

endmodule

// File: rtl/hyst_trigger.sv
module hyst_trigger
  import hyst_trigger_pkg::*;
#(
  parameter int SAMPLE_W    = 14,
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                armEn,
  input  logic                modeDigital,
  input  logic                slopeFall,
  input  logic                digLevel,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] trigLevel,
  input  logic [SAMPLE_W-1:0] hystWidth,
  input  logic [CNT_W-1:0]    minWidth,
  input  logic                digIn,
  output logic                trigOut
);

  dpFlags_t  flags;
  ctrlStrb_t strb;

  hyst_trigger_dp #(
    .SAMPLE_W   (SAMPLE_W),
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .slopeFall  (slopeFall),
    .sampleIn   (sampleIn),
    .sampleValid(sampleValid),
    .trigLevel  (trigLevel),
    .hystWidth  (hystWidth),
    .minWidth   (minWidth),
    .digIn      (digIn),
    .strb       (strb),
    .flags      (flags)
  );

  hyst_trigger_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .armEn      (armEn),
    .modeDigital(modeDigital),
    .digLevel   (digLevel),
    .flags      (flags),
    .strb       (strb),
    .trigOut    (trigOut)
  );

endmodule

// File: tb/hyst_trigger_bench.sv
module hyst_trigger_bench;

  localparam int SW = 8;
  localparam int CW = 4;
  localparam int SMAX = 127;
  localparam int SMIN = -128;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          armEn = 1'b0, modeDigital = 1'b0, slopeFall = 1'b0, digLevel = 1'b0;
  logic [SW-1:0] sampleIn = '0, trigLevel = '0, hystWidth = '0;
  logic          sampleValid = 1'b0, digIn = 1'b0;
  logic [CW-1:0] minWidth = '0;
  logic          trigOut;

  always #2.5 clk = ~clk;

  hyst_trigger #(.SAMPLE_W(SW), .CNT_W(CW), .SYNC_STAGES(2)) u_hyst_trigger (
    .clk(clk), .rstN(rstN), .armEn(armEn), .modeDigital(modeDigital),
    .slopeFall(slopeFall), .digLevel(digLevel), .sampleIn(sampleIn),
    .sampleValid(sampleValid), .trigLevel(trigLevel), .hystWidth(hystWidth),
    .minWidth(minWidth), .digIn(digIn), .trigOut(trigOut));

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  int    expCyc[$];
  string curReq = "R1";

  // model configuration and state
  int cfgLvl, cfgHy, cfgMw;
  bit cfgFall, cfgDig, cfgLvlMode;
  bit mReady;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (trigOut) begin
        if (expCyc.size() > 0 && expCyc[0] == cyc) begin
          chk(1'b1, curReq, "trigger cycle", cyc, cyc);
          void'(expCyc.pop_front());
        end else begin
          chk(1'b0, curReq, "unexpected trigger at cycle", cyc,
              (expCyc.size() > 0) ? expCyc[0] : -1);
        end
      end
      while (expCyc.size() > 0 && expCyc[0] < cyc) begin
        chk(1'b0, curReq, "missed trigger, seen cycle", cyc, expCyc[0]);
        void'(expCyc.pop_front());
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      sampleValid = 1'b0;
    end
  endtask

  task automatic configure(input bit dig, input bit fall, input bit lvlMode,
                           input int lvl, input int hy, input int mw, input string req);
    @(posedge clk); #1;
    armEn = 1'b0; sampleValid = 1'b0; digIn = 1'b0;
    modeDigital = dig; slopeFall = fall; digLevel = lvlMode;
    trigLevel = SW'(lvl); hystWidth = SW'(hy); minWidth = CW'(mw);
    cfgDig = dig; cfgFall = fall; cfgLvlMode = lvlMode; cfgLvl = lvl; cfgHy = hy; cfgMw = mw;
    curReq = req;
    repeat (2) @(posedge clk);
    #1 armEn = 1'b1; mReady = 1'b0;
    idle(3);
  endtask

  task automatic phaseEnd(input string req);
    idle(8);
    chk(expCyc.size() == 0, req, "pending expected triggers", expCyc.size(), 0);
    expCyc.delete();
  endtask

  // drive one sample; the model decides whether it fires (R2..R7)
  task automatic sample(input int v, input bit valid);
    int lo, hi;
    bit fire, rearm;
    @(posedge clk); #1;
    sampleIn = SW'(v); sampleValid = valid;
    lo = cfgLvl - cfgHy; if (lo < SMIN) lo = SMIN;
    hi = cfgLvl + cfgHy; if (hi > SMAX) hi = SMAX;
    fire  = cfgFall ? (v <= cfgLvl) : (v >= cfgLvl);
    rearm = cfgFall ? (v > hi) : (v < lo);
    if (armEn && valid && !cfgDig) begin
      if (mReady && fire) begin
        expCyc.push_back(cyc + 1);
        mReady = 1'b0;
      end else if (!mReady && rearm) begin
        mReady = 1'b1;
      end
    end
  endtask

  // drive a pin pulse seen high at n clock edges (R8..R10)
  task automatic dpulse(input int n);
    int p, meff;
    @(posedge clk); #1;
    p = cyc;
    digIn = 1'b1;
    meff = (cfgMw < 1) ? 1 : cfgMw;
    if (armEn && cfgDig && n >= meff) begin
      if (cfgLvlMode) begin
        for (int k = p + 2 + meff; k <= p + n + 2; k++) expCyc.push_back(k);
      end else begin
        expCyc.push_back(p + 2 + meff);
      end
    end
    repeat (n) @(posedge clk);
    #1 digIn = 1'b0;
    idle(6);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(trigOut == 1'b0, "R1", "trigOut after reset", int'(trigOut), 0);

    // R1: disarmed, crossings and pulses do nothing
    cfgDig = 0; cfgFall = 0; cfgLvl = 20; cfgHy = 10; cfgMw = 1; curReq = "R1";
    trigLevel = 8'd20; hystWidth = 8'd10; minWidth = 4'd1;
    sample(0, 1); sample(50, 1); sample(0, 1); sample(50, 1);
    modeDigital = 1'b1; cfgDig = 1;
    dpulse(5);
    phaseEnd("R1");

    // R2 + R4: rising slope with hysteresis re-arm
    configure(0, 0, 0, 20, 10, 0, "R2");
    sample(25, 1);                 // not ready yet after arming: no fire
    sample(0, 1); sample(25, 1);   // re-arm, fire
    curReq = "R4";
    sample(30, 1); sample(15, 1); sample(22, 1); // inside band: nothing
    sample(10, 1); sample(21, 1);  // 10 not below 10: nothing
    sample(9, 1); sample(20, 1);   // re-arm, fire at equality
    phaseEnd("R4");

    // R3 + R5: falling slope
    configure(0, 1, 0, -10, 6, 0, "R3");
    sample(0, 1); sample(-10, 1);  // re-arm, fire at equality
    curReq = "R5";
    sample(-20, 1); sample(-5, 1); sample(-4, 1); sample(-30, 1); // no re-arm
    sample(-3, 1); sample(-11, 1); // re-arm, fire
    phaseEnd("R5");

    // R2: zero hysteresis
    configure(0, 0, 0, 0, 0, 0, "R2");
    sample(-1, 1); sample(0, 1); sample(-1, 1); sample(1, 1); sample(5, 1);
    phaseEnd("R2");

    // R6: clamped band never re-arms (a wrapped band would)
    configure(0, 0, 0, -120, 50, 0, "R6");
    sample(-128, 1); sample(127, 1); sample(0, 1); sample(127, 1); sample(-128, 1);
    phaseEnd("R6");
    configure(0, 1, 0, 120, 50, 0, "R6");
    sample(127, 1); sample(-128, 1); sample(0, 1); sample(-128, 1);
    phaseEnd("R6");

    // R7: invalid samples ignored
    configure(0, 0, 0, 20, 10, 0, "R7");
    sample(0, 0); sample(100, 1);  // invalid re-arm ignored: no fire
    sample(0, 1); sample(100, 0); sample(100, 0); // ready, invalid high ignored
    sample(100, 1);                // fires now
    phaseEnd("R7");

    // R11: disarm loses readiness
    configure(0, 0, 0, 20, 10, 0, "R11");
    sample(0, 1);
    @(posedge clk); #1 armEn = 1'b0; sampleValid = 1'b0;
    sample(30, 1);
    @(posedge clk); #1 armEn = 1'b1; mReady = 1'b0; sampleValid = 1'b0;
    idle(2);
    sample(30, 1); sample(0, 1); sample(30, 1);
    phaseEnd("R11");

    // R8 + R10: edge response with minimum width 3
    configure(1, 0, 0, 0, 0, 3, "R10");
    dpulse(2);
    curReq = "R8";
    dpulse(3); dpulse(8);
    phaseEnd("R8");

    // R8: minimum width zero behaves as one
    configure(1, 0, 0, 0, 0, 0, "R8");
    dpulse(1); dpulse(4);
    phaseEnd("R8");

    // R9: level response
    configure(1, 0, 1, 0, 0, 3, "R9");
    dpulse(5); dpulse(3);
    curReq = "R10";
    dpulse(2);
    phaseEnd("R9");

    // R10: counter saturation with the widest minimum
    configure(1, 0, 1, 0, 0, 15, "R10");
    dpulse(14); dpulse(20);
    phaseEnd("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule